// File: doc/BRIEF.md
# Packed Lane Logical Right Shifter

This block shifts a 128-bit vector right, treating it as four separate 32-bit lanes. One unsigned shift count applies to every lane. Bits never pass from one lane into the next, and the high-order bits that the shift empties are filled with zeros. Each shifted lane goes back into the position it came from.

The count can come from either of two inputs, chosen by a select line. In vector form it is the low 64 bits of a second 128-bit operand. In immediate form it is an 8-bit immediate. The whole count is compared as an unsigned number, so any value above 31 clears the entire result instead of wrapping modulo 32. The result is registered and is marked valid one clock after the input strobe.

Top module: `lane_srl`

## Requirements
- R1: Lanes sit at bits [31:0], [63:32], [95:64] and [127:96] of the data input. Each lane is shifted on its own, and no bit crosses a lane boundary.
- R2: The vacated high-order bits of every lane are filled with zeros.
- R3: When `cnt_sel_imm` is 0, the count is bits [63:0] of `cnt_vec_i`, and bits [127:64] of `cnt_vec_i` have no effect on the result.
- R4: When `cnt_sel_imm` is 1, the count is the 8-bit `cnt_imm_i`, and `cnt_vec_i` has no effect on the result.
- R5: A count greater than 31 drives all 128 result bits to zero. The comparison uses the full unsigned count and never wraps modulo 32. This covers immediate values 32 to 255 and vector counts with any bit set above bit 4, including 2^63.
- R6: All four lanes use the same count, and each result lane stays in the position of its source lane.
- R7: A count of zero passes every lane through unchanged.
- R8: `res_vld_o` is high exactly one clock after `in_vld_i` is high, and `res_o` then holds the result for that input. Synchronous reset clears `res_vld_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Input operands valid |
| data_i | input | 128 | Four packed 32-bit lanes to shift |
| cnt_vec_i | input | 128 | Vector count source; only the low 64 bits are used |
| cnt_imm_i | input | 8 | Immediate count source |
| cnt_sel_imm | input | 1 | 1 selects the immediate count, 0 selects the vector count |
| res_vld_o | output | 1 | Result valid, one clock after in_vld_i |
| res_o | output | 128 | Shifted lanes |

## Verification
The bench targets count values at the edges of the saturation rule: 31, 32, 255 and 2^63, plus a count whose low five bits are zero but whose upper bits are set. A design that wraps modulo 32 or looks only at the low byte would pass data through or shift it wrongly in these cases instead of clearing it. Garbage in the ignored upper half of the vector operand, and in the unselected source, exposes a design that reads the wrong bits. Patterns with a one in the low bit of a lane next to the high bit of the neighbouring lane reveal shifts that leak across lanes or sign-fill.

// File: rtl/lane_srl_pkg.sv
package lane_srl_pkg;
    parameter int LANE_W   = 32;
    parameter int LANES    = 4;
    parameter int VEC_W    = LANE_W * LANES;
    parameter int CNT_W    = 64;
    parameter int IMM_W    = 8;
    localparam int SH_W    = $clog2(LANE_W);

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {SRC_VEC = 1'b0, SRC_IMM = 1'b1} cnt_src_e;

    typedef struct packed {
        logic            zero_all;
        logic [SH_W-1:0] amt;
    } shamt_t;

    function automatic shamt_t decode_cnt(input cnt_t c);
        shamt_t s;
        s.zero_all = (c > cnt_t'(LANE_W - 1));
        s.amt      = c[SH_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/lane_srl_cnt.sv
module lane_srl_cnt
    import lane_srl_pkg::*;
(
    input  logic [VEC_W-1:0] cnt_vec_i,
    input  logic [IMM_W-1:0] cnt_imm_i,
    input  cnt_src_e         src_i,
    output shamt_t           sh_o
);
    cnt_t cnt;

    always_comb begin
        if (src_i == SRC_IMM) cnt = cnt_t'(cnt_imm_i);
        else                  cnt = cnt_vec_i[CNT_W-1:0];
    end

    assign sh_o = decode_cnt(cnt);

    always_comb begin
        assert_saturate_R5: assert (!(cnt >= cnt_t'(LANE_W)) || sh_o.zero_all)
            else $error("R5 count above lane width not saturating");
    end
endmodule

// File: rtl/lane_srl_lane.sv
module lane_srl_lane
    import lane_srl_pkg::*;
(
    input  lane_t  lane_i,
    input  shamt_t sh_i,
    output lane_t  lane_o
);
    lane_t stage [SH_W+1];

    assign stage[0] = lane_i;

    generate
        for (genvar b = 0; b < SH_W; b++) begin : g_stage
            assign stage[b+1] = sh_i.amt[b] ? (stage[b] >> (1 << b)) : stage[b];
        end
    endgenerate

    assign lane_o = sh_i.zero_all ? '0 : stage[SH_W];

    always_comb begin
        assert_zero_pass_R7: assert (sh_i.zero_all || sh_i.amt != '0 || lane_o == lane_i)
            else $error("R7 zero count altered lane");
    end
endmodule

// File: rtl/lane_srl.sv
module lane_srl
    import lane_srl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld_i,
    input  logic [VEC_W-1:0]   data_i,
    input  logic [VEC_W-1:0]   cnt_vec_i,
    input  logic [IMM_W-1:0]   cnt_imm_i,
    input  logic               cnt_sel_imm,
    output logic               res_vld_o,
    output logic [VEC_W-1:0]   res_o
);
    shamt_t           sh;
    logic [VEC_W-1:0] shifted;

    lane_srl_cnt u_cnt (
        .cnt_vec_i (cnt_vec_i),
        .cnt_imm_i (cnt_imm_i),
        .src_i     (cnt_src_e'(cnt_sel_imm)),
        .sh_o      (sh)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            lane_srl_lane u_lane (
                .lane_i (data_i[l*LANE_W +: LANE_W]),
                .sh_i   (sh),
                .lane_o (shifted[l*LANE_W +: LANE_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) res_vld_o <= 1'b0;
        else     res_vld_o <= in_vld_i;
    end

    always_ff @(posedge clk) begin
        if (in_vld_i) res_o <= shifted;
    end

    assert_vld_delay_R8: assert property (@(posedge clk) disable iff (rst)
        in_vld_i |=> res_vld_o);
    assert_vld_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> !res_vld_o);
    assert_imm_big_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && cnt_sel_imm && cnt_imm_i > 8'd31) |=> res_o == '0);
    assert_vec_big_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && !cnt_sel_imm && cnt_vec_i[63:5] != '0) |=> res_o == '0);
    assert_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> $stable(res_o));
endmodule

// File: tb/lane_srl_bench.sv
module lane_srl_bench;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 0;
    logic         rst;
    logic         in_vld_i;
    logic [127:0] data_i, cnt_vec_i;
    logic [7:0]   cnt_imm_i;
    logic         cnt_sel_imm;
    logic         res_vld_o;
    logic [127:0] res_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_srl u_lane_srl (.*);

    function automatic logic [127:0] model(input logic [127:0] d, input logic [63:0] c);
        logic [127:0] r;
        for (int l = 0; l < 4; l++)
            r[l*32 +: 32] = (c > 64'd31) ? 32'd0 : (d[l*32 +: 32] >> c[4:0]);
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Apply one operation, sample after the registering edge.
    task automatic apply(input string req, input logic [127:0] d, input logic [127:0] cv,
                         input logic [7:0] ci, input logic sel);
        logic [63:0] c;
        c = sel ? {56'd0, ci} : cv[63:0];
        @(negedge clk);
        data_i = d; cnt_vec_i = cv; cnt_imm_i = ci; cnt_sel_imm = sel; in_vld_i = 1;
        @(negedge clk);
        in_vld_i = 0;
        check({req, " vld"}, {127'd0, res_vld_o}, 128'd1);
        check(req, res_o, model(d, c));
    endtask

    task automatic t_reset;
        rst = 1; in_vld_i = 0; data_i = '0; cnt_vec_i = '0; cnt_imm_i = 0; cnt_sel_imm = 0;
        repeat (2) @(negedge clk);
        check("R8 reset", {127'd0, res_vld_o}, 128'd0);
        rst = 0;
        @(negedge clk);
        check("R8 idle", {127'd0, res_vld_o}, 128'd0);
    endtask

    task automatic t_lane_isolation;
        // R1 R2: lane low bit next to neighbour's high bit
        apply("R1", 128'h80000001_80000001_80000001_80000001, 128'd1, 0, 0);
        apply("R2", 128'hFFFFFFFF_80000000_FFFFFFFF_80000000, 128'd31, 0, 0);
        apply("R6", 128'h12345678_9ABCDEF0_0F1E2D3C_4B5A6978, 128'd4, 0, 0);
    endtask

    task automatic t_sources;
        apply("R3", 128'hDEADBEEF_CAFEBABE_01234567_89ABCDEF,
              {64'hFFFF_FFFF_FFFF_FFFF, 64'd8}, 8'd200, 0);
        apply("R4", 128'hDEADBEEF_CAFEBABE_01234567_89ABCDEF,
              {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF}, 8'd12, 1);
    endtask

    task automatic t_saturation;
        logic [127:0] d = 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF;
        apply("R5 c31", d, 128'd31, 0, 0);
        apply("R5 c32", d, 128'd32, 0, 0);
        apply("R5 imm32", d, 128'd0, 8'd32, 1);
        apply("R5 imm255", d, 128'd0, 8'd255, 1);
        apply("R5 2^63", d, {64'd0, 64'h8000_0000_0000_0000}, 0, 0);
        apply("R5 hi-wrap", d, {64'd0, 64'h0000_0001_0000_0000}, 0, 0);
        apply("R5 imm31", d, 128'd0, 8'd31, 1);
    endtask

    task automatic t_zero;
        apply("R7 vec", 128'h89ABCDEF_01234567_FEDCBA98_76543210, {64'hAAAA, 64'd0}, 8'd9, 0);
        apply("R7 imm", 128'h89ABCDEF_01234567_FEDCBA98_76543210, 128'd5, 8'd0, 1);
    endtask

    task automatic t_valid_gap;
        // R8: no strobe -> no valid, result held
        @(negedge clk);
        check("R8 gap", {127'd0, res_vld_o}, 128'd0);
        for (int i = 0; i < 3; i++)
            apply("R8 b2b", {4{32'hF0F0_0F0F >> i}}, 128'(i * 7), 0, 0);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_lane_isolation;
                t_sources;
                t_saturation;
                t_zero;
                t_valid_gap;
            end
            begin
                repeat (5000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule